// File: doc/BRIEF.md
# Bootstrap Charge Switch Enable Controller

This block decides, cycle by cycle, whether the integrated bootstrap charging switch of a half-bridge gate driver may conduct. It watches the high-side and low-side drive outputs and the raw logic inputs that command them. It also watches a comparator flag, already synchronised to the clock, that is high when the floating supply sits above roughly 1.1 times the logic supply. From these it produces one enable, `sw_en`. The switch is meant for complementary PWM only, where the two inputs take turns.

There are three ways the enable can turn on. The first is direct: the low-side output is on and the floating supply is low. The second is a window that opens when the low-side input falls. This window runs for a fixed time and then closes, whatever the flag does. The third is a window that opens when the high-side input falls. Its timer is held cleared while the flag is high, so it only closes after `WIN_CYC` consecutive low-flag cycles.

The state machine has three states: `ST_IDLE`, `ST_LS_WIN` (one-shot window) and `ST_HS_WIN` (retriggerable window). Its transitions are:
- **ABORT**: any state goes to `ST_IDLE` while `hs_drv` is high.
- **OPEN_LS**: any state goes to `ST_LS_WIN` on an accepted low-side falling edge.
- **OPEN_HS**: any state goes to `ST_HS_WIN` on an accepted high-side falling edge.
- **CANCEL**: a window state goes to `ST_IDLE` when `ls_drv` is high.
- **EXPIRE**: a window state goes to `ST_IDLE` when the timer reaches `WIN_CYC-1` while counting.
- **HOLD**: every other case keeps the current state.

The default `WIN_CYC` is 2500 cycles, which is 20 µs at 125 MHz.

Top module: `boot_switch_ctrl`

## Requirements
- R1: An active-low reset, applied asynchronously, returns the controller to `ST_IDLE` with the timer cleared. After reset, with both drive outputs low and the flag low, `sw_en` is 0.
- R2: While `hs_drv` is 1, `sw_en` is 0 in that same cycle, whatever the other inputs and the state are.
- R3: While `vfloat_hi` is 1, `sw_en` is 0 in that same cycle.
- R4: While `ls_drv` is 1, `hs_drv` is 0 and `vfloat_hi` is 0, `sw_en` is 1 in that same cycle.
- R5: A low-side falling edge is `ls_in` sampled 1 at one rising clock edge and 0 at the next, with `hs_drv` 0 at the second edge. It opens a window that covers the `WIN_CYC` clock periods after that edge. In those periods `sw_en` is 1 whenever the flag and both drive outputs are low.
- R6: The low-side window is a one-shot. It closes exactly `WIN_CYC` periods after its edge, whether or not the flag was high during it.
- R7: A high-side falling edge (`hs_in` 1 then 0, with `hs_drv` 0) opens a retriggerable window. Its counter is held at zero in every period the flag is high, and the window closes after `WIN_CYC` consecutive flag-low periods.
- R8: Once a window has closed, `sw_en` stays 0 until a new falling edge or until `ls_drv` goes high.
- R9: `ls_drv` going high during a window ends that window. When `ls_drv` drops again without a new edge, `sw_en` is 0.
- R10: `hs_drv` high during a window ends that window, and falling edges sampled while `hs_drv` is high are dropped. When `hs_drv` drops again without a new edge, `sw_en` is 0.
- R11: A falling edge that arrives during a window restarts the timer in the mode of the new edge. If both edges come in the same cycle, the low-side edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_in | input | 1 | Raw high-side logic input |
| ls_in | input | 1 | Raw low-side logic input |
| hs_drv | input | 1 | High-side drive output is on |
| ls_drv | input | 1 | Low-side drive output is on |
| vfloat_hi | input | 1 | Floating supply is above about 1.1 times the logic supply |
| sw_en | output | 1 | Bootstrap switch enable |

## Verification
The overrides (R2, R3) and the direct path (R4) are combinational, so `sw_en` must change in the same clock period as the input that causes it. Edges and timer decisions are registered once. A window is therefore first visible in the period after the rising edge that samples the falling input, and it ends `WIN_CYC` periods later; for the high-side window, that count runs from the last period in which the flag was high. The bench changes inputs on falling clock edges and reads `sw_en` 2 ns later. This way each check sees exactly one cycle's combination of inputs and registered state. Expected window lengths are counted period by period against a small `WIN_CYC`, which makes the one-shot and retriggerable cases end at different rows.

// File: rtl/boot_switch_pkg.sv
package boot_switch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LS_WIN = 2'd1,
        ST_HS_WIN = 2'd2
    } bsw_state_e;

endpackage

// File: rtl/boot_switch_edge.sv
module boot_switch_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= din[i];
        end
        assign fall[i] = prev_q[i] & ~din[i];
    end

endmodule

// File: rtl/boot_switch_timer.sv
module boot_switch_timer #(
    parameter int LIM = 2500
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clr,
    input  logic                                 inc,
    output logic [((LIM > 1) ? $clog2(LIM) : 1)-1:0] cnt,
    output logic                                 done
);

    localparam int CW = (LIM > 1) ? $clog2(LIM) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIM - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);

    // R5: the count never passes the last window cycle
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/boot_switch_fsm.sv
module boot_switch_fsm
    import boot_switch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_drv,
    input  logic       ls_drv,
    input  logic       flag_hi,
    input  logic       ls_fall,
    input  logic       hs_fall,
    input  logic       tmr_done,
    output bsw_state_e state,
    output logic       tmr_clr,
    output logic       tmr_inc,
    output logic       win_open
);

    bsw_state_e nxt;
    logic       take_ls;
    logic       take_hs;

    assign take_ls = ~hs_drv & ls_fall;
    assign take_hs = ~hs_drv & hs_fall & ~ls_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (hs_drv) begin
            nxt = ST_IDLE;                       // ABORT
        end else if (take_ls) begin
            nxt = ST_LS_WIN;                     // OPEN_LS
        end else if (take_hs) begin
            nxt = ST_HS_WIN;                     // OPEN_HS
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_IDLE;
                ST_LS_WIN: begin
                    if (ls_drv)        nxt = ST_IDLE;   // CANCEL
                    else if (tmr_done) nxt = ST_IDLE;   // EXPIRE
                end
                ST_HS_WIN: begin
                    if (ls_drv)                    nxt = ST_IDLE; // CANCEL
                    else if (!flag_hi && tmr_done) nxt = ST_IDLE; // EXPIRE
                end
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        win_open = (state != ST_IDLE);
        tmr_clr  = take_ls | take_hs | (state == ST_IDLE)
                 | ((state == ST_HS_WIN) & flag_hi);
        tmr_inc  = win_open & ~tmr_clr & ~tmr_done;
    end

    // R10: high-side drive always returns the machine to idle
    p_hs_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hs_drv |=> state == ST_IDLE);

    // R9: low-side drive cancels an open window
    p_ls_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && ls_drv && !hs_drv && !ls_fall && !hs_fall) |=> state == ST_IDLE);

    // R11: the low-side edge wins when both edges come together
    p_edge_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_fall && hs_fall && !hs_drv) |=> state == ST_LS_WIN);

endmodule

// File: rtl/boot_switch_ctrl.sv
module boot_switch_ctrl
    import boot_switch_pkg::*;
#(
    parameter int WIN_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_in,
    input  logic ls_in,
    input  logic hs_drv,
    input  logic ls_drv,
    input  logic vfloat_hi,
    output logic sw_en
);

    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

    logic [1:0]    falls;
    logic          ls_fall;
    logic          hs_fall;
    logic          tmr_clr;
    logic          tmr_inc;
    logic          tmr_done;
    logic          win_open;
    logic [CW-1:0] cnt;
    bsw_state_e    state;

    boot_switch_edge #(.N(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({hs_in, ls_in}),
        .fall  (falls)
    );

    assign ls_fall = falls[0];
    assign hs_fall = falls[1];

    boot_switch_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_drv   (hs_drv),
        .ls_drv   (ls_drv),
        .flag_hi  (vfloat_hi),
        .ls_fall  (ls_fall),
        .hs_fall  (hs_fall),
        .tmr_done (tmr_done),
        .state    (state),
        .tmr_clr  (tmr_clr),
        .tmr_inc  (tmr_inc),
        .win_open (win_open)
    );

    boot_switch_timer #(.LIM(WIN_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .cnt   (cnt),
        .done  (tmr_done)
    );

    // The output gate is combinational, so both overrides act in the same cycle.
    assign sw_en = ~hs_drv & ~vfloat_hi & (ls_drv | win_open);

    p_hs_override_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_drv |-> !sw_en);

    p_flag_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vfloat_hi |-> !sw_en);

    p_ls_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_drv && !hs_drv && !vfloat_hi) |-> sw_en);

    // R7: the high-side window counter is held cleared while the flag is high
    p_hs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HS_WIN && vfloat_hi && !hs_drv && !ls_fall && !hs_fall) |=> cnt == '0);

    // R6: the one-shot window keeps counting regardless of the flag
    p_oneshot_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LS_WIN && !ls_drv && !hs_drv && !ls_fall && !hs_fall && !tmr_done)
        |=> (state == ST_LS_WIN && cnt == $past(cnt) + 1'b1));

    // R8: an expired window falls back to idle
    p_expire_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && tmr_done && !vfloat_hi && !hs_drv && !ls_fall && !hs_fall) |=> state == ST_IDLE);

endmodule

// File: tb/boot_switch_ctrl_test.sv
module boot_switch_ctrl_test;

    localparam int W = 8;
    localparam int NV = 39;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_in = 1'b0, ls_in = 1'b0, hs_drv = 1'b0, ls_drv = 1'b0, vfloat_hi = 1'b0;
    logic sw_en;
    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    boot_switch_ctrl #(.WIN_CYC(W)) uut (
        .clk (clk), .rst_n (rst_n), .hs_in (hs_in), .ls_in (ls_in),
        .hs_drv (hs_drv), .ls_drv (ls_drv), .vfloat_hi (vfloat_hi), .sw_en (sw_en)
    );

    // {hs_in, ls_in, hs_drv, ls_drv, vfloat_hi, expected, requirement}
    localparam logic [9:0] VEC [0:NV-1] = '{
        {5'b01010, 1'b1, 4'd4},   // 0  R4 direct path
        {5'b01011, 1'b0, 4'd3},   // 1  R3 flag blocks
        {5'b01110, 1'b0, 4'd2},   // 2  R2 high side overrides
        {5'b01010, 1'b1, 4'd4},   // 3  R4
        {5'b00001, 1'b0, 4'd3},   // 4  low-side edge sampled at the end
        {5'b00001, 1'b0, 4'd6},   // 5  R6 window period 0, flag high
        {5'b00001, 1'b0, 4'd6},   // 6
        {5'b00001, 1'b0, 4'd6},   // 7
        {5'b00000, 1'b1, 4'd5},   // 8  R5 period 3
        {5'b00000, 1'b1, 4'd5},   // 9
        {5'b00000, 1'b1, 4'd5},   // 10
        {5'b00000, 1'b1, 4'd5},   // 11
        {5'b00000, 1'b1, 4'd5},   // 12 period 7, last
        {5'b00000, 1'b0, 4'd6},   // 13 R6 fixed end
        {5'b00000, 1'b0, 4'd6},   // 14
        {5'b00000, 1'b0, 4'd6},   // 15
        {5'b00001, 1'b0, 4'd8},   // 16 R8 stays off
        {5'b00000, 1'b0, 4'd8},   // 17
        {5'b10100, 1'b0, 4'd2},   // 18 R2 high side on
        {5'b00001, 1'b0, 4'd3},   // 19 high-side edge sampled at the end
        {5'b00001, 1'b0, 4'd7},   // 20 R7 held while flag high
        {5'b00001, 1'b0, 4'd7},   // 21
        {5'b00001, 1'b0, 4'd7},   // 22
        {5'b00000, 1'b1, 4'd7},   // 23 count 0
        {5'b00000, 1'b1, 4'd7},   // 24
        {5'b00000, 1'b1, 4'd7},   // 25
        {5'b00000, 1'b1, 4'd7},   // 26 count 3
        {5'b00001, 1'b0, 4'd7},   // 27 retrigger
        {5'b00000, 1'b1, 4'd7},   // 28 count 0 again
        {5'b00000, 1'b1, 4'd7},   // 29
        {5'b00000, 1'b1, 4'd7},   // 30
        {5'b00000, 1'b1, 4'd7},   // 31
        {5'b00000, 1'b1, 4'd7},   // 32
        {5'b00000, 1'b1, 4'd7},   // 33
        {5'b00000, 1'b1, 4'd7},   // 34
        {5'b00000, 1'b1, 4'd7},   // 35 count 7, last
        {5'b00000, 1'b0, 4'd7},   // 36 R7 expired
        {5'b00001, 1'b0, 4'd8},   // 37 R8
        {5'b00000, 1'b0, 4'd8}    // 38 R8 no reopen
    };

    task automatic check(input logic exp, input string tag);
        n_run++;
        if (sw_en !== exp) begin
            n_fail++;
            $display("FAIL %s: sw_en=%0b expected=%0b", tag, sw_en, exp);
        end
    endtask

    task automatic cyc(input logic h, input logic l, input logic hd, input logic ld,
                       input logic f, input logic exp, input string tag);
        @(negedge clk);
        hs_in = h; ls_in = l; hs_drv = hd; ls_drv = ld; vfloat_hi = f;
        #2;
        check(exp, tag);
    endtask

    initial begin
        #6;
        check(1'b0, "R1 during reset");
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 1'b0, "R1 after reset");

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4],
                $sformatf("R%0d row %0d", VEC[i][3:0], i));
        end

        // R9: low-side drive cancels a window
        cyc(0, 1, 0, 1, 0, 1'b1, "R4 before cancel");
        cyc(0, 0, 0, 0, 0, 1'b0, "R5 edge period");
        cyc(0, 0, 0, 0, 0, 1'b1, "R5 window open");
        cyc(0, 0, 0, 1, 0, 1'b1, "R4 inside window");
        cyc(0, 0, 0, 0, 0, 1'b0, "R9 cancelled");
        cyc(0, 0, 0, 0, 0, 1'b0, "R9 still off");

        // R10: high-side drive ends a window
        cyc(1, 0, 0, 0, 0, 1'b0, "R10 setup");
        cyc(0, 0, 0, 0, 0, 1'b0, "R10 edge period");
        cyc(0, 0, 0, 0, 0, 1'b1, "R7 window open");
        cyc(0, 0, 1, 0, 0, 1'b0, "R2 inside window");
        cyc(0, 0, 0, 0, 0, 1'b0, "R10 ended");

        // R11: high-side edge during a low-side window restarts in the new mode
        cyc(0, 1, 0, 0, 0, 1'b0, "R11 setup");
        cyc(0, 0, 0, 0, 0, 1'b0, "R11 low edge");
        for (int p = 0; p < 3; p++) cyc(0, 0, 0, 0, 0, 1'b1, "R5 early period");
        cyc(1, 0, 0, 0, 0, 1'b1, "R5 period 3");
        cyc(1, 0, 0, 0, 0, 1'b1, "R5 period 4");
        cyc(0, 0, 0, 0, 0, 1'b1, "R11 high edge");
        for (int p = 0; p < W; p++) cyc(0, 0, 0, 0, 0, 1'b1, "R11 extended window");
        cyc(0, 0, 0, 0, 0, 1'b0, "R11 new window ends");

        // R1: reset in the middle of a window
        cyc(0, 1, 0, 0, 0, 1'b0, "R1 setup");
        cyc(0, 0, 0, 0, 0, 1'b0, "R1 edge");
        cyc(0, 0, 0, 0, 0, 1'b1, "R5 before reset");
        @(negedge clk); rst_n = 1'b0;
        #2; check(1'b0, "R1 reset asserted");
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 1'b0, "R1 window cleared");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule